// File: doc/BRIEF.md
# Transmit Drain Timing Tracker

This block produces the holding-register-empty and transmitter-empty status of a buffered serial transmitter that has no real shift register behind it. Each byte written while the transmitter is in buffered mode is accounted for as one character time on the line. The two empty flags drop as soon as a byte is written. They come back only when a computed completion time has passed.

The completion time is anchored at the first byte of a burst, which is any write that finds no bytes outstanding. The k-th byte of the burst, counted from zero, moves the completion time to the anchor plus k character times. The character time follows the live line format: data length, parity and stop bits, multiplied by a bit period in clock cycles that is set by a parameter. When the completion time is reached, the empty flags rise and an empty interrupt becomes pending. A read of the interrupt identification that reports this interrupt clears the pending flag. In direct (unbuffered) mode a write never holds the flags low.

Top module: `tx_drain_tracker`

## Requirements
- R1: During and after a synchronous reset, thr_empty and tx_empty are 1 and empty_irq_pend is 0.
- R2: The character length in bits is 1 start bit, plus 1 if fmt_parity_en is set, plus 5 + fmt_data_len (code 0..3 means 5..8 data bits), plus 1 stop bit, or 2 if fmt_two_stop is set. The character time is that count times BIT_CYCLES clock cycles.
- R3: A write in buffered mode (wr_stb with fifo_mode = 1) clears thr_empty, tx_empty and empty_irq_pend at that clock edge.
- R4: A buffered write that finds no bytes outstanding anchors the burst at its own edge. The write that finds k bytes outstanding sets the completion edge to the anchor edge plus k character times. If that edge has already passed, completion comes on the next edge without a write.
- R5: At the completion edge the outstanding count returns to zero, thr_empty and tx_empty rise, and empty_irq_pend is set. A lone byte therefore completes one edge after its write.
- R6: A write in direct mode (fifo_mode = 0) sets thr_empty, tx_empty and empty_irq_pend at its edge and abandons any burst in progress, so no later completion follows.
- R7: A pulse on irq_id_read clears empty_irq_pend at the next edge. A completion or a direct-mode write on the same edge takes priority and leaves the flag set.
- R8: Between a buffered write and its completion, thr_empty and tx_empty stay low and always equal each other.
- R9: A buffered write that arrives after a completion starts a new burst, timed from its own edge and not from the old anchor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | One-cycle pulse: a byte written to the transmit holding register |
| fifo_mode | input | 1 | 1 = buffered mode, 0 = direct mode |
| fmt_data_len | input | 2 | Data length code, 0..3 means 5..8 bits |
| fmt_parity_en | input | 1 | Parity bit present in each character |
| fmt_two_stop | input | 1 | Two stop bits instead of one |
| irq_id_read | input | 1 | Interrupt identification read that reports the empty interrupt |
| thr_empty | output | 1 | Transmit holding register empty |
| tx_empty | output | 1 | Transmitter completely empty |
| empty_irq_pend | output | 1 | Empty interrupt pending |

## Verification
A wrong outstanding count or a wrong anchor shows up as empty flags that rise too early or too late. The error in the rise cycle is a whole multiple of the character time, so the bench measures the exact edge of the rise after every burst, for every line format. A burst that was not abandoned, or a count that did not return to zero, shows up within one character time as an extra completion or a shifted completion edge. The bench catches these by clearing the pending flag and watching it across the following window. A priority error between reading and setting the pending flag shows up on the very next edge.

// File: rtl/tdt_pkg.sv
`timescale 1ns/1ps
package tdt_pkg;

    typedef enum logic [1:0] {
        DLEN_5 = 2'd0,
        DLEN_6 = 2'd1,
        DLEN_7 = 2'd2,
        DLEN_8 = 2'd3
    } dlen_e;

    typedef struct packed {
        dlen_e data_len;
        logic  parity_en;
        logic  two_stop;
    } line_fmt_t;

    // Events raised by the timing logic for the status flags.
    typedef struct packed {
        logic wr_buf;    // buffered write this cycle
        logic wr_direct; // direct-mode write this cycle
        logic fire;      // completion time reached
        logic ack;       // interrupt identification read
    } tdt_evt_t;

    localparam int MAX_CHAR_BITS = 12;

    // start + data + parity + stop
    function automatic logic [3:0] char_bits(line_fmt_t f);
        return 4'd7 + 4'(f.data_len) + 4'(f.parity_en) + 4'(f.two_stop);
    endfunction

endpackage

// File: rtl/tdt_char_time.sv
`timescale 1ns/1ps
module tdt_char_time
    import tdt_pkg::*;
#(
    parameter int BIT_CYCLES = 16,
    parameter int CT_W       = $clog2(MAX_CHAR_BITS * BIT_CYCLES + 1)
) (
    input  line_fmt_t       fmt,
    output logic [CT_W-1:0] char_cycles
);

    always_comb begin
        char_cycles = CT_W'(char_bits(fmt)) * CT_W'(BIT_CYCLES);
    end

endmodule

// File: rtl/tdt_deadline.sv
`timescale 1ns/1ps
module tdt_deadline #(
    parameter int CNT_MAX = 16,
    parameter int CT_W    = 8,
    parameter int TIME_W  = 12
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_buf,
    input  logic            wr_direct,
    input  logic [CT_W-1:0] char_cycles,
    output logic            fire
);

    localparam int CNT_W = $clog2(CNT_MAX + 1);

    logic [CNT_W-1:0]  cnt;
    logic [TIME_W-1:0] elapsed;
    logic [TIME_W-1:0] deadline;
    logic              active;
    logic [CNT_W-1:0]  cnt_inc;
    logic [TIME_W:0]   now_ext;

    assign active  = (cnt != '0);
    assign cnt_inc = (cnt == CNT_W'(CNT_MAX)) ? cnt : cnt + 1'b1;
    assign now_ext = {1'b0, elapsed} + 1'b1;
    assign fire    = active && !wr_buf && !wr_direct && (now_ext >= {1'b0, deadline});

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            elapsed  <= '0;
            deadline <= '0;
        end else if (wr_buf) begin
            if (!active) begin
                elapsed  <= '0;
                deadline <= '0;
            end else begin
                elapsed  <= elapsed + 1'b1;
                deadline <= TIME_W'(cnt) * TIME_W'(char_cycles);
            end
            cnt <= cnt_inc;
        end else if (wr_direct) begin
            cnt <= '0;
        end else if (fire) begin
            cnt <= '0;
        end else if (active) begin
            elapsed <= elapsed + 1'b1;
        end
    end

    p_anchor_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_buf && !active) |=> (elapsed == '0 && deadline == '0 && cnt == CNT_W'(1)));

    p_fire_idles_r5: assert property (@(posedge clk) disable iff (rst)
        fire |=> !active);

    p_direct_abandons_r6: assert property (@(posedge clk) disable iff (rst)
        wr_direct |=> !active);

endmodule

// File: rtl/tdt_flags.sv
`timescale 1ns/1ps
module tdt_flags
    import tdt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  tdt_evt_t evt,
    output logic     thre,
    output logic     temt,
    output logic     pend
);

    always_ff @(posedge clk) begin
        if (rst) begin
            thre <= 1'b1;
            temt <= 1'b1;
            pend <= 1'b0;
        end else if (evt.wr_buf) begin
            thre <= 1'b0;
            temt <= 1'b0;
            pend <= 1'b0;
        end else if (evt.wr_direct || evt.fire) begin
            thre <= 1'b1;
            temt <= 1'b1;
            pend <= 1'b1;
        end else if (evt.ack) begin
            pend <= 1'b0;
        end
    end

    p_buf_wr_clears_r3: assert property (@(posedge clk) disable iff (rst)
        evt.wr_buf |=> (!thre && !temt && !pend));

    p_direct_sets_r6: assert property (@(posedge clk) disable iff (rst)
        (evt.wr_direct && !evt.wr_buf) |=> (thre && temt && pend));

    p_fire_sets_r5: assert property (@(posedge clk) disable iff (rst)
        evt.fire |=> (thre && temt && pend));

    p_ack_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (evt.ack && !evt.wr_buf && !evt.wr_direct && !evt.fire) |=> !pend);

    p_pair_equal_r8: assert property (@(posedge clk) disable iff (rst)
        thre == temt);

endmodule

// File: rtl/tx_drain_tracker.sv
`timescale 1ns/1ps
module tx_drain_tracker
    import tdt_pkg::*;
#(
    parameter int BIT_CYCLES = 16,
    parameter int CNT_MAX    = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_stb,
    input  logic       fifo_mode,
    input  logic [1:0] fmt_data_len,
    input  logic       fmt_parity_en,
    input  logic       fmt_two_stop,
    input  logic       irq_id_read,
    output logic       thr_empty,
    output logic       tx_empty,
    output logic       empty_irq_pend
);

    localparam int CT_W   = $clog2(MAX_CHAR_BITS * BIT_CYCLES + 1);
    localparam int TIME_W = $clog2(CNT_MAX * MAX_CHAR_BITS * BIT_CYCLES + 2);

    line_fmt_t       fmt;
    logic [CT_W-1:0] char_cycles;
    tdt_evt_t        evt;
    logic            fire;

    assign fmt = '{data_len: dlen_e'(fmt_data_len),
                   parity_en: fmt_parity_en,
                   two_stop: fmt_two_stop};

    assign evt = '{wr_buf: wr_stb && fifo_mode,
                   wr_direct: wr_stb && !fifo_mode,
                   fire: fire,
                   ack: irq_id_read};

    tdt_char_time #(
        .BIT_CYCLES (BIT_CYCLES),
        .CT_W       (CT_W)
    ) u_char_time (
        .fmt         (fmt),
        .char_cycles (char_cycles)
    );

    tdt_deadline #(
        .CNT_MAX (CNT_MAX),
        .CT_W    (CT_W),
        .TIME_W  (TIME_W)
    ) u_deadline (
        .clk         (clk),
        .rst         (rst),
        .wr_buf      (evt.wr_buf),
        .wr_direct   (evt.wr_direct),
        .char_cycles (char_cycles),
        .fire        (fire)
    );

    tdt_flags u_flags (
        .clk  (clk),
        .rst  (rst),
        .evt  (evt),
        .thre (thr_empty),
        .temt (tx_empty),
        .pend (empty_irq_pend)
    );

endmodule

// File: tb/tb_tx_drain_tracker.sv
`timescale 1ns/1ps
module tb_tx_drain_tracker;

    localparam int BC = 3;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_stb;
    logic       fifo_mode;
    logic [1:0] fmt_data_len;
    logic       fmt_parity_en;
    logic       fmt_two_stop;
    logic       irq_id_read;
    logic       thr_empty;
    logic       tx_empty;
    logic       empty_irq_pend;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    tx_drain_tracker #(.BIT_CYCLES(BC), .CNT_MAX(15)) dut (
        .clk            (clk),
        .rst            (rst),
        .wr_stb         (wr_stb),
        .fifo_mode      (fifo_mode),
        .fmt_data_len   (fmt_data_len),
        .fmt_parity_en  (fmt_parity_en),
        .fmt_two_stop   (fmt_two_stop),
        .irq_id_read    (irq_id_read),
        .thr_empty      (thr_empty),
        .tx_empty       (tx_empty),
        .empty_irq_pend (empty_irq_pend)
    );

    task automatic chk(bit ok, string req, int act, int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_ct(int dl, int par, int st);
        return (1 + par + 5 + dl + 1 + st) * BC;
    endfunction

    // Inputs change just after a falling edge; outputs are read there too.
    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_write(bit fm);
        wr_stb    = 1'b1;
        fifo_mode = fm;
        step();
        wr_stb    = 1'b0;
    endtask

    task automatic do_ack();
        irq_id_read = 1'b1;
        step();
        irq_id_read = 1'b0;
    endtask

    // Counts edges until thr_empty rises; also checks the drain window (R8).
    task automatic wait_empty(output int k, output bit bad);
        k   = 0;
        bad = 1'b0;
        while (!thr_empty && k < 5000) begin
            if (tx_empty || empty_irq_pend) bad = 1'b1;
            step();
            k++;
        end
        if (thr_empty != tx_empty) bad = 1'b1;
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int k;
        bit bad;
        int ct;
        int exp;
        rst = 1'b1; wr_stb = 1'b0; fifo_mode = 1'b1; irq_id_read = 1'b0;
        fmt_data_len = 2'd3; fmt_parity_en = 1'b0; fmt_two_stop = 1'b0;
        step(); step();
        chk(thr_empty && tx_empty && !empty_irq_pend, "R1 in reset",
            {thr_empty, tx_empty, empty_irq_pend}, 3'b110);
        rst = 1'b0;
        step();
        chk(thr_empty && tx_empty && !empty_irq_pend, "R1 after reset",
            {thr_empty, tx_empty, empty_irq_pend}, 3'b110);

        // Sweep every line format and several burst lengths (R2, R3, R5, R8, R9).
        for (int f = 0; f < 16; f++) begin
            fmt_data_len  = f[1:0];
            fmt_parity_en = f[2];
            fmt_two_stop  = f[3];
            ct = exp_ct(f[1:0], f[2], f[3]);
            for (int b = 0; b < 4; b++) begin
                int n;
                n = (b == 0) ? 1 : (b == 1) ? 2 : (b == 2) ? 3 : 6;
                for (int i = 0; i < n; i++) do_write(1'b1);
                chk(!thr_empty && !tx_empty && !empty_irq_pend, "R3 buffered write clears",
                    {thr_empty, tx_empty, empty_irq_pend}, 0);
                wait_empty(k, bad);
                exp = (n == 1) ? 1 : (n - 1) * ct - (n - 1);
                chk(k == exp, "R2 R5 completion edge", k, exp);
                chk(!bad, "R8 flags low and equal while draining", bad, 0);
                chk(tx_empty && empty_irq_pend, "R5 flags at completion",
                    {tx_empty, empty_irq_pend}, 2'b11);
                do_ack();
                chk(!empty_irq_pend && thr_empty, "R7 read clears pending",
                    {thr_empty, empty_irq_pend}, 2'b10);
            end
        end

        // R4: spaced write keeps the anchor of the first byte.
        fmt_data_len = 2'd3; fmt_parity_en = 1'b0; fmt_two_stop = 1'b0;
        ct = exp_ct(3, 0, 0);
        do_write(1'b1);
        do_write(1'b1);
        for (int i = 0; i < 8; i++) step();
        do_write(1'b1);
        wait_empty(k, bad);
        exp = 2 * ct - 10;
        chk(k == exp, "R4 deadline from anchor", k, exp);
        chk(!bad, "R8 spaced burst drain", bad, 0);
        do_ack();

        // R9: a new burst after idle is timed from its own start.
        for (int i = 0; i < 20; i++) step();
        do_write(1'b1);
        do_write(1'b1);
        wait_empty(k, bad);
        chk(k == ct - 1, "R9 new burst anchor", k, ct - 1);
        do_ack();

        // R6: direct-mode write.
        do_write(1'b0);
        chk(thr_empty && tx_empty && empty_irq_pend, "R6 direct write sets flags",
            {thr_empty, tx_empty, empty_irq_pend}, 3'b111);
        do_ack();
        // R6: direct write abandons a burst in progress.
        do_write(1'b1); do_write(1'b1); do_write(1'b1);
        do_write(1'b0);
        chk(thr_empty && tx_empty && empty_irq_pend, "R6 direct write mid-burst",
            {thr_empty, tx_empty, empty_irq_pend}, 3'b111);
        do_ack();
        bad = 1'b0;
        for (int i = 0; i < 3 * ct; i++) begin
            step();
            if (empty_irq_pend || !thr_empty) bad = 1'b1;
        end
        chk(!bad, "R6 no completion after abandon", bad, 0);

        // R7: completion on the same edge as the read wins.
        do_write(1'b1);
        irq_id_read = 1'b1;
        step();
        irq_id_read = 1'b0;
        chk(empty_irq_pend && thr_empty, "R7 completion beats read",
            {thr_empty, empty_irq_pend}, 2'b11);
        do_ack();
        chk(!empty_irq_pend, "R7 read alone clears", empty_irq_pend, 0);
        // R7: direct write on the same edge as the read wins.
        irq_id_read = 1'b1;
        do_write(1'b0);
        irq_id_read = 1'b0;
        chk(empty_irq_pend, "R7 direct write beats read", empty_irq_pend, 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule